// File: doc/BRIEF.md
# Single-Accumulator Processor with Self-Modifying Store

This block is a small processor built around one accumulator register. Every instruction takes two consecutive words of a unified program/data memory. The first word names the operation and the second holds an immediate value or an address. There is a single memory port, and it carries instruction fetches, data reads and data writes alike. Because of this a store may land on the operand word of an instruction further down the program.

The machine has no index or address register, so a store to a computed address is done by patching. The program first writes the target address into the operand word of a later store instruction. That store then uses the patched word. The operand word is always read from memory during the instruction that uses it, so a patch is seen the next time the patched instruction runs.

Each instruction occupies three clock cycles: opcode read, operand read and execute. A loop counter is kept in memory. A compare sets a less-or-equal flag, and a conditional jump uses that flag to repeat the loop while the counter stays at or below a limit. An operation word that is not recognised stops the machine. The accumulator and the program counter are brought out as debug views.

Top module: `acc_patch_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `pc_dbg`=0, `acc_dbg`=0 and `halt`=0, and `mem_we` stays low. The jump flag is also cleared, so a conditional jump that runs before any compare falls through.
- R2: Every instruction takes exactly three cycles. The first reads the operation word at `pc`, the second reads the operand word at `pc`+1, and the third executes. An instruction that does not jump advances `pc` by 2 at the end of its third cycle.
- R3: An operation word is legal only when bits [DW-1:4] are zero and bits [3:0] hold one of these codes: 1 load-immediate, 2 load-direct, 3 load-indirect, 4 add-immediate, 5 add-memory, 6 shift-left, 7 store, 8 compare, 9 jump-if-less-or-equal.
- R4: Load-immediate (1) sets the accumulator to the operand word. Load-direct (2) sets the accumulator to the memory word at the address given by the operand.
- R5: Load-indirect (3) uses the low AW bits of the accumulator as an address and replaces the accumulator with the word found there. Its operand word has no effect.
- R6: Add-immediate (4) adds the operand word to the accumulator, and add-memory (5) adds the word at the operand address. Both wrap modulo 2^DW.
- R7: Shift-left (6) shifts the accumulator left by the operand's low log2(DW) bits and fills with zeros. The operand's upper bits are ignored.
- R8: Store (7) writes the accumulator to the operand address, in the execute cycle only, as one single-cycle write. The accumulator is unchanged, and the target may be any word, including program words.
- R9: A store that overwrites the operand word of a later instruction changes what that instruction does the next time it runs. A loop that patches its own store address fills an array element by element.
- R10: Compare (8) sets the flag to (accumulator <= operand), both taken as unsigned. It leaves the accumulator unchanged.
- R11: Jump-if-less-or-equal (9) loads `pc` with the low AW bits of its operand when the flag is set. When the flag is clear, `pc` advances by 2.
- R12: An illegal operation word raises `halt` in the cycle after it is read. From then on `halt`, `pc_dbg` and `acc_dbg` hold and no writes occur, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | AW | Address for the unified memory |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_wdata | output | DW | Write data (accumulator) |
| mem_rdata | input | DW | Read data for `mem_addr`, same cycle |
| halt | output | 1 | Machine stopped on an illegal word |
| acc_dbg | output | DW | Accumulator view |
| pc_dbg | output | AW | Program counter view |

## Verification
Each data operation is first run as a one-instruction program, with operands chosen so that each operation gives a result none of the others would give. Carry wrap, a shift by zero, by the maximum amount and with junk in the upper operand bits, and an indirect load whose operand word is a decoy show whether the right operand field and width are used. The compare and jump pair is tried just below, at and above the limit, and at the top of the range, which tells an unsigned less-or-equal test apart from a strict or signed one. A jump with no earlier compare shows the flag's reset value. A 101-pass loop that patches its own store address tells a design that rereads the operand word apart from one that reuses a stale value. Illegal words with junk either in the upper bits or in the code field check that the machine stops and stays stopped.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [3:0] {
        OP_LDI = 4'd1,
        OP_LDD = 4'd2,
        OP_LDX = 4'd3,
        OP_ADI = 4'd4,
        OP_ADD = 4'd5,
        OP_SHL = 4'd6,
        OP_STR = 4'd7,
        OP_CMP = 4'd8,
        OP_JLE = 4'd9
    } opcode_e;

    typedef enum logic [1:0] {
        ST_OP   = 2'd0,
        ST_IMM  = 2'd1,
        ST_EXE  = 2'd2,
        ST_HALT = 2'd3
    } state_e;

    typedef struct packed {
        logic addr_from_acc;
        logic wr_acc;
        logic wr_mem;
        logic set_flag;
        logic branch;
    } ctl_t;

    function automatic logic code_known(input logic [3:0] code);
        return (code >= 4'd1) && (code <= 4'd9);
    endfunction

    function automatic ctl_t ctl_of(input opcode_e op);
        ctl_t c;
        c = '0;
        case (op)
            OP_LDI, OP_LDD, OP_ADI, OP_ADD, OP_SHL: c.wr_acc = 1'b1;
            OP_LDX: begin
                c.wr_acc        = 1'b1;
                c.addr_from_acc = 1'b1;
            end
            OP_STR: c.wr_mem   = 1'b1;
            OP_CMP: c.set_flag = 1'b1;
            OP_JLE: c.branch   = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] word,
    output opcode_e       op,
    output logic          legal
);
    localparam int CODE_W = 4;

    always_comb begin
        legal = (word[DW-1:CODE_W] == '0) && code_known(word[CODE_W-1:0]);
        op    = legal ? opcode_e'(word[CODE_W-1:0]) : OP_LDI;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DW = 16
) (
    input  opcode_e       op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] imm,
    input  logic [DW-1:0] mdata,
    output logic [DW-1:0] result,
    output logic          le
);
    localparam int SHW = $clog2(DW);

    logic [SHW-1:0] shamt;

    always_comb begin
        shamt = imm[SHW-1:0];
        le    = (acc <= imm);
        case (op)
            OP_LDI:         result = imm;
            OP_LDD, OP_LDX: result = mdata;
            OP_ADI:         result = acc + imm;
            OP_ADD:         result = acc + mdata;
            OP_SHL:         result = acc << shamt;
            default:        result = acc;
        endcase
    end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dec_legal,
    input  opcode_e       dec_op,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] alu_result,
    input  logic          alu_le,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          halt,
    output opcode_e       op_q,
    output logic [DW-1:0] imm_q,
    output logic [DW-1:0] acc_q,
    output logic [AW-1:0] pc_q
);
    localparam logic [AW-1:0] STEP = AW'(2);

    state_e state;
    logic   flag_q;
    ctl_t   ctl;
    logic   taken;

    always_comb begin
        ctl   = ctl_of(op_q);
        taken = ctl.branch && flag_q;
        case (state)
            ST_OP:   mem_addr = pc_q;
            ST_IMM:  mem_addr = pc_q + AW'(1);
            ST_EXE:  mem_addr = ctl.addr_from_acc ? acc_q[AW-1:0] : imm_q[AW-1:0];
            default: mem_addr = pc_q;
        endcase
        mem_we    = (state == ST_EXE) && ctl.wr_mem;
        mem_wdata = acc_q;
        halt      = (state == ST_HALT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_OP;
            pc_q   <= '0;
            acc_q  <= '0;
            flag_q <= 1'b0;
            op_q   <= OP_LDI;
            imm_q  <= '0;
        end else begin
            case (state)
                ST_OP: begin
                    if (dec_legal) begin
                        op_q  <= dec_op;
                        state <= ST_IMM;
                    end else begin
                        state <= ST_HALT;
                    end
                end
                ST_IMM: begin
                    imm_q <= mem_rdata;
                    state <= ST_EXE;
                end
                ST_EXE: begin
                    if (ctl.wr_acc)   acc_q  <= alu_result;
                    if (ctl.set_flag) flag_q <= alu_le;
                    pc_q  <= taken ? imm_q[AW-1:0] : pc_q + STEP;
                    state <= ST_OP;
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXE && !ctl.branch) |=> (pc_q == $past(pc_q) + STEP));

    // R11
    jle_target_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXE && ctl.branch && flag_q) |=> (pc_q == $past(imm_q[AW-1:0])));

    // R12
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> (halt && $stable(pc_q) && $stable(acc_q) && !mem_we));

    // R8
    store_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R10
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXE && ctl.set_flag) |=> $stable(acc_q));
endmodule

// File: rtl/acc_patch_cpu.sv
module acc_patch_cpu
    import acc_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          halt,
    output logic [DW-1:0] acc_dbg,
    output logic [AW-1:0] pc_dbg
);
    opcode_e       dec_op;
    logic          dec_legal;
    opcode_e       op_q;
    logic [DW-1:0] imm_q;
    logic [DW-1:0] acc_q;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] alu_result;
    logic          alu_le;

    acc_decode #(.DW(DW)) u_dec (
        .word  (mem_rdata),
        .op    (dec_op),
        .legal (dec_legal)
    );

    acc_alu #(.DW(DW)) u_alu (
        .op     (op_q),
        .acc    (acc_q),
        .imm    (imm_q),
        .mdata  (mem_rdata),
        .result (alu_result),
        .le     (alu_le)
    );

    acc_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .dec_legal  (dec_legal),
        .dec_op     (dec_op),
        .mem_rdata  (mem_rdata),
        .alu_result (alu_result),
        .alu_le     (alu_le),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .halt       (halt),
        .op_q       (op_q),
        .imm_q      (imm_q),
        .acc_q      (acc_q),
        .pc_q       (pc_q)
    );

    assign acc_dbg = acc_q;
    assign pc_dbg  = pc_q;
endmodule

// File: tb/acc_patch_cpu_test.sv
`timescale 1ns/1ps
module acc_patch_cpu_test;
    localparam int DW    = 16;
    localparam int AW    = 9;
    localparam int DEPTH = 1 << AW;
    localparam int DADR  = 'h1E0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          halt;
    logic [DW-1:0] acc_dbg;
    logic [AW-1:0] pc_dbg;

    logic [DW-1:0] mem [DEPTH];
    int wr_count = 0;
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    acc_patch_cpu #(.DW(DW), .AW(AW)) uut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halt(halt),
        .acc_dbg(acc_dbg), .pc_dbg(pc_dbg)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we === 1'b1) begin
            mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    // vector: op[67:64] imm[63:48] acc_init[47:32] mval[31:16] expected_acc[15:0]
    localparam int NV = 12;
    localparam logic [67:0] VEC [NV] = '{
        {4'd1, 16'h1234, 16'h0000, 16'h0000, 16'h1234},  // R4 load-immediate
        {4'd2, 16'h01E0, 16'h0005, 16'hBEEF, 16'hBEEF},  // R4 load-direct
        {4'd3, 16'h0055, 16'h01E0, 16'h4242, 16'h4242},  // R5 indirect, decoy operand
        {4'd4, 16'h0010, 16'h00F5, 16'h0000, 16'h0105},  // R6 add-immediate
        {4'd4, 16'h0002, 16'hFFFF, 16'h0000, 16'h0001},  // R6 wrap
        {4'd5, 16'h01E0, 16'h0100, 16'h0023, 16'h0123},  // R6 add-memory
        {4'd6, 16'h0004, 16'h0123, 16'h0000, 16'h1230},  // R7 shift 4
        {4'd6, 16'h0013, 16'h0001, 16'h0000, 16'h0008},  // R7 upper bits ignored
        {4'd6, 16'h000F, 16'h0003, 16'h0000, 16'h8000},  // R7 max shift
        {4'd6, 16'h0000, 16'hA5A5, 16'h0000, 16'hA5A5},  // R7 zero shift
        {4'd8, 16'h0050, 16'h0007, 16'h0000, 16'h0007},  // R10 acc kept
        {4'd7, 16'h01E0, 16'h7777, 16'h0000, 16'h7777}   // R8 store
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    endtask

    task automatic put(input int a, input logic [DW-1:0] v);
        mem[a] = v;
    endtask

    task automatic start();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_halt(input int limit, input string req);
        int n;
        n = 0;
        while (halt !== 1'b1 && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (halt !== 1'b1) check(req, 32'd0, 32'd1);
    endtask

    initial begin
        logic [67:0] v;
        int          wsnap;
        logic [DW-1:0] cmpv [4];
        logic [AW-1:0] cmpexp [4];

        // R1 reset state and R2 cycle timing
        clear_mem();
        put(0, 16'd1); put(1, 16'd5); put(2, 16'd1); put(3, 16'd6); put(4, 16'd0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 pc after reset", 32'(pc_dbg), 32'd0);
        check("R1 acc after reset", 32'(acc_dbg), 32'd0);
        check("R1 halt after reset", 32'(halt), 32'd0);
        check("R1 no write in reset", 32'(mem_we), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R2 pc held after two cycles", 32'(pc_dbg), 32'd0);
        @(negedge clk);
        check("R2 pc after three cycles", 32'(pc_dbg), 32'd2);
        check("R4 acc after first load", 32'(acc_dbg), 32'd5);
        run_to_halt(50, "R2 run");
        check("R2 pc at end", 32'(pc_dbg), 32'd4);
        check("R4 acc at end", 32'(acc_dbg), 32'd6);

        // single-instruction vectors
        for (int k = 0; k < NV; k++) begin
            v = VEC[k];
            clear_mem();
            put(0, 16'd1); put(1, v[47:32]); put(2, 16'(v[67:64]));
            put(3, v[63:48]); put(4, 16'd0); put(DADR, v[31:16]);
            start();
            run_to_halt(50, "R3 vector run");
            check($sformatf("R3 vector %0d acc (op %0d)", k, v[67:64]), 32'(acc_dbg), 32'(v[15:0]));
            check($sformatf("R2 vector %0d pc", k), 32'(pc_dbg), 32'd4);
            if (v[67:64] == 4'd7)
                check("R8 stored word", 32'(mem[DADR]), 32'(v[15:0]));
        end

        // R11 flag cleared by reset: jump falls through
        clear_mem();
        put(0, 16'd9); put(1, 16'h0040); put(2, 16'd0);
        start();
        run_to_halt(50, "R11 run");
        check("R11 jump without compare falls through", 32'(pc_dbg), 32'd2);

        // R10/R11 compare boundaries
        cmpv[0] = 16'd0;   cmpexp[0] = 9'h040;
        cmpv[1] = 16'd100; cmpexp[1] = 9'h040;
        cmpv[2] = 16'd101; cmpexp[2] = 9'd6;
        cmpv[3] = 16'hFFFF; cmpexp[3] = 9'd6;
        for (int k = 0; k < 4; k++) begin
            clear_mem();
            put(0, 16'd1); put(1, cmpv[k]); put(2, 16'd8); put(3, 16'd100);
            put(4, 16'd9); put(5, 16'h0040); put(6, 16'd0); put('h40, 16'd0);
            start();
            run_to_halt(50, "R11 cmp run");
            check($sformatf("R11 jump target for acc=%0d", cmpv[k]), 32'(pc_dbg), 32'(cmpexp[k]));
            check("R10 acc kept by compare", 32'(acc_dbg), 32'(cmpv[k]));
        end

        // R9 self-patching loop: A[i] = B[i] + C for i = 0..100
        clear_mem();
        for (int i = 0; i <= 101; i++) begin
            put('h100 + i, 16'(3 * i + 7));
            put('h180 + i, 16'hDEAD);
        end
        put('h1F1, 16'd1000);
        put(0, 16'd1);  put(1, 16'd0);
        put(2, 16'd7);  put(3, 16'h1F0);
        put(4, 16'd2);  put(5, 16'h1F0);
        put(6, 16'd4);  put(7, 16'h180);
        put(8, 16'd7);  put(9, 16'd19);
        put(10, 16'd2); put(11, 16'h1F0);
        put(12, 16'd4); put(13, 16'h100);
        put(14, 16'd3); put(15, 16'd0);
        put(16, 16'd5); put(17, 16'h1F1);
        put(18, 16'd7); put(19, 16'h0000);
        put(20, 16'd2); put(21, 16'h1F0);
        put(22, 16'd4); put(23, 16'd1);
        put(24, 16'd7); put(25, 16'h1F0);
        put(26, 16'd8); put(27, 16'd100);
        put(28, 16'd9); put(29, 16'd4);
        put(30, 16'd0);
        wsnap = wr_count;
        start();
        run_to_halt(20000, "R9 loop run");
        check("R9 loop halts at end", 32'(pc_dbg), 32'd30);
        check("R9 counter final", 32'(mem['h1F0]), 32'd101);
        check("R9 patched operand word", 32'(mem[19]), 32'(16'h180 + 16'd100));
        check("R8 store count", 32'(wr_count - wsnap), 32'd304);
        for (int i = 0; i <= 100; i++)
            check($sformatf("R9 A[%0d]", i), 32'(mem['h180 + i]), 32'(3 * i + 1007));
        check("R9 A[101] untouched", 32'(mem['h180 + 101]), 32'hDEAD);

        // R12 illegal word with upper bits set
        clear_mem();
        put(0, 16'd1); put(1, 16'd9); put(2, 16'h0010);
        start();
        run_to_halt(50, "R12 run");
        check("R12 pc at illegal word", 32'(pc_dbg), 32'd2);
        check("R12 acc kept", 32'(acc_dbg), 32'd9);
        wsnap = wr_count;
        repeat (10) @(negedge clk);
        check("R12 halt held", 32'(halt), 32'd1);
        check("R12 pc held", 32'(pc_dbg), 32'd2);
        check("R12 no writes while halted", 32'(wr_count - wsnap), 32'd0);

        // R3/R12 unknown code halts one cycle after read
        clear_mem();
        put(0, 16'h000A);
        start();
        check("R12 halt low right after reset", 32'(halt), 32'd0);
        @(negedge clk);
        check("R3 code 10 halts", 32'(halt), 32'd1);
        check("R3 pc at code 10", 32'(pc_dbg), 32'd0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R12 reset clears halt", 32'(halt), 32'd0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule